// File: doc/BRIEF.md
# Four-Channel Prioritized DMA Scheduler

This block decides which of four DMA channels a transfer unit works on next. Software loads each channel's control bits through a per-channel write strobe. The control bits are enable, timing mode, repeat, interrupt enable and a cartridge-request bit. Video blanking pulses and a special trigger then mark channels pending. A start-immediately timing mode marks a channel pending as soon as it is written.

The scheduler serves one channel at a time. It selects the lowest-numbered pending channel and pulses a start strobe with that channel's index. It then waits for the transfer unit to report completion. On completion it clears that channel's pending flag and raises the channel's interrupt flag if interrupts are enabled for it. It then rescans from channel 0. It stays busy until a scan finds nothing pending.

Timing mode encoding: 0 = start on write, 1 = vertical blank, 2 = horizontal blank, 3 = special trigger. Only the last channel honours mode 3. That channel can also raise a separate cartridge interrupt.

Top module: `dma_sched`

## Requirements
- R1: After reset, busy, start, every interrupt flag and the cartridge flag are low, and no channel is pending, so no start appears without a new trigger.
- R2: A one-cycle vblank pulse marks pending every enabled channel with timing mode 1. A one-cycle hblank pulse does the same for timing mode 2. Channels in other modes are unaffected.
- R3: The special trigger marks pending only channel 3, and only when it is enabled with timing mode 3. Channels 0 to 2 in mode 3 never become pending from any trigger.
- R4: A disabled channel is never pending and is never started. A configuration write with enable 0 clears the channel's pending flag.
- R5: Channel 0 has the highest priority and channel 3 the lowest. After every completion the scan restarts from channel 0.
- R6: Start is a one-cycle pulse, and sel_ch holds the served channel. Only one channel is outstanding at a time. Busy rises with the first start and falls once a scan finds no channel pending.
- R7: When a channel completes with its interrupt-enable bit set, its bit in irq_flags is set. Flags are sticky until a 1 is written on the matching irq_clr bit, and a set wins over a clear in the same cycle.
- R8: When channel 3 completes with its cartridge-request bit set, cart_irq is set. It is sticky until cart_clr.
- R9: With repeat 0, completion clears the channel's enable, so later triggers are ignored. With repeat 1, the channel stays enabled and is served again on its next trigger.
- R10: A configuration write with enable 1 and timing mode 0 marks the channel pending at once.
- R11: Trigger pulses are sampled every cycle, including while another channel is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NUM_CH | Per-channel control write strobe |
| cfg_enable | input | 1 | Enable bit to write |
| cfg_mode | input | 2 | Timing mode to write |
| cfg_repeat | input | 1 | Repeat bit to write |
| cfg_irq_en | input | 1 | Interrupt-enable bit to write |
| cfg_drq | input | 1 | Cartridge-request bit to write |
| vblank | input | 1 | Vertical blank pulse |
| hblank | input | 1 | Horizontal blank pulse |
| special_trig | input | 1 | Special trigger pulse |
| xfer_done | input | 1 | Transfer unit finished the started channel |
| irq_clr | input | NUM_CH | Write-one-to-clear for irq_flags |
| cart_clr | input | 1 | Clear for cart_irq |
| sel_ch | output | CH_W | Channel being served |
| start | output | 1 | One-cycle start strobe |
| busy | output | 1 | Scheduler is serving channels |
| irq_flags | output | NUM_CH | Sticky per-channel interrupt flags |
| cart_irq | output | 1 | Sticky cartridge interrupt flag |

## Verification
A corrupt pending flag appears at the ports within two cycles of the event that caused it. It shows as a start for a channel that should be idle, or as a missing start after a trigger. A wrong priority order or a missed rescan shows on sel_ch at the very next start after a completion. A lost interrupt or cartridge flag is visible one cycle after the done that should have set it.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    TM_NOW     = 2'd0,
    TM_VBLANK  = 2'd1,
    TM_HBLANK  = 2'd2,
    TM_SPECIAL = 2'd3
  } tmode_t;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_WAIT = 1'b1
  } sched_st_t;
endpackage

// File: rtl/dma_sched_chan.sv
module dma_sched_chan
  import dma_sched_pkg::*;
#(
  parameter bit HONOR_SPECIAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic       cfg_enable,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_repeat,
  input  logic       cfg_irq_en,
  input  logic       cfg_drq,
  input  logic       vblank,
  input  logic       hblank,
  input  logic       special_trig,
  input  logic       done_this,
  output logic       pending,
  output logic       irq_en,
  output logic       drq
);
  tmode_t mode_q;
  logic   en_q, rep_q, ie_q, drq_q, pend_q;
  logic   trig_hit, special_ok;

  assign special_ok = HONOR_SPECIAL & special_trig;

  always_comb begin
    trig_hit = en_q & ~(done_this & ~rep_q) &
               (((mode_q == TM_VBLANK)  & vblank) |
                ((mode_q == TM_HBLANK)  & hblank) |
                ((mode_q == TM_SPECIAL) & special_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TM_NOW;
      en_q   <= 1'b0;
      rep_q  <= 1'b0;
      ie_q   <= 1'b0;
      drq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (done_this) begin
        pend_q <= 1'b0;
        if (!rep_q) en_q <= 1'b0;
      end
      if (trig_hit) pend_q <= 1'b1;
      if (cfg_we) begin
        en_q   <= cfg_enable;
        mode_q <= tmode_t'(cfg_mode);
        rep_q  <= cfg_repeat;
        ie_q   <= cfg_irq_en;
        drq_q  <= cfg_drq;
        if (cfg_enable && (tmode_t'(cfg_mode) == TM_NOW)) pend_q <= 1'b1;
        else if (!cfg_enable) pend_q <= 1'b0;
      end
    end
  end

  assign pending = pend_q;
  assign irq_en  = ie_q;
  assign drq     = drq_q;

  // R4: a disabled channel never holds pending
  a_r4_no_pend_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !pend_q);

  // R9: one-shot channel drops its enable after completing
  a_r9_oneshot_disable: assert property (@(posedge clk) disable iff (rst)
    (done_this && !rep_q && !cfg_we) |=> !en_q);
endmodule

// File: rtl/dma_sched_prio.sv
module dma_sched_prio #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic [CH_W-1:0]   pick,
  output logic              any
);
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) pick = CH_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_sched_fsm.sv
module dma_sched_fsm
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_pend,
  input  logic [CH_W-1:0]   pick,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic              drq_last,
  input  logic              xfer_done,
  input  logic [NUM_CH-1:0] irq_clr,
  input  logic              cart_clr,
  output logic [NUM_CH-1:0] done_vec,
  output logic [CH_W-1:0]   sel_ch,
  output logic              start,
  output logic              busy,
  output logic [NUM_CH-1:0] irq_flags,
  output logic              cart_irq
);
  sched_st_t         st_q;
  logic [NUM_CH-1:0] irq_set;
  logic              cart_set;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      done_vec[i] = (st_q == ST_WAIT) && xfer_done && (sel_ch == CH_W'(i));
    end
  end

  assign irq_set  = done_vec & irq_en;
  assign cart_set = done_vec[NUM_CH-1] & drq_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_SCAN;
      sel_ch    <= '0;
      start     <= 1'b0;
      busy      <= 1'b0;
      irq_flags <= '0;
      cart_irq  <= 1'b0;
    end else begin
      start <= 1'b0;
      case (st_q)
        ST_SCAN: begin
          if (any_pend) begin
            sel_ch <= pick;
            start  <= 1'b1;
            busy   <= 1'b1;
            st_q   <= ST_WAIT;
          end else begin
            busy <= 1'b0;
          end
        end
        default: begin
          if (xfer_done) st_q <= ST_SCAN;
        end
      endcase
      irq_flags <= (irq_flags & ~irq_clr) | irq_set;
      cart_irq  <= (cart_irq & ~cart_clr) | cart_set;
    end
  end

  // R6: start lasts exactly one cycle and only while busy
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  a_r6_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |-> busy);

  // R8: cartridge flag only rises after a done on the last channel
  a_r8_cart_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(cart_irq) |-> $past(xfer_done && busy && (sel_ch == CH_W'(NUM_CH-1))));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_irq_chk
      // R7: a channel flag only rises after a done for that channel
      a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flags[g]) |-> $past(xfer_done && busy && (sel_ch == CH_W'(g))));
    end
  endgenerate
endmodule

// File: rtl/dma_sched.sv
module dma_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cfg_we,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_repeat,
  input  logic              cfg_irq_en,
  input  logic              cfg_drq,
  input  logic              vblank,
  input  logic              hblank,
  input  logic              special_trig,
  input  logic              xfer_done,
  input  logic [NUM_CH-1:0] irq_clr,
  input  logic              cart_clr,
  output logic [CH_W-1:0]   sel_ch,
  output logic              start,
  output logic              busy,
  output logic [NUM_CH-1:0] irq_flags,
  output logic              cart_irq
);
  logic [NUM_CH-1:0] pend, ie, drq, done_vec;
  logic [CH_W-1:0]   pick;
  logic              any_pend;
  logic [NUM_CH-1:0] higher_mask;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      dma_sched_chan #(.HONOR_SPECIAL(g == NUM_CH - 1)) u_chan (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we[g]),
        .cfg_enable   (cfg_enable),
        .cfg_mode     (cfg_mode),
        .cfg_repeat   (cfg_repeat),
        .cfg_irq_en   (cfg_irq_en),
        .cfg_drq      (cfg_drq),
        .vblank       (vblank),
        .hblank       (hblank),
        .special_trig (special_trig),
        .done_this    (done_vec[g]),
        .pending      (pend[g]),
        .irq_en       (ie[g]),
        .drq          (drq[g])
      );
    end
  endgenerate

  dma_sched_prio #(.NUM_CH(NUM_CH)) u_prio (
    .req  (pend),
    .pick (pick),
    .any  (any_pend)
  );

  dma_sched_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .any_pend  (any_pend),
    .pick      (pick),
    .irq_en    (ie),
    .drq_last  (drq[NUM_CH-1]),
    .xfer_done (xfer_done),
    .irq_clr   (irq_clr),
    .cart_clr  (cart_clr),
    .done_vec  (done_vec),
    .sel_ch    (sel_ch),
    .start     (start),
    .busy      (busy),
    .irq_flags (irq_flags),
    .cart_irq  (cart_irq)
  );

  assign higher_mask = (NUM_CH'(1) << sel_ch) - NUM_CH'(1);

  // R5: no higher-priority channel was pending when a channel was started
  a_r5_priority: assert property (@(posedge clk) disable iff (rst)
    start |-> (($past(pend) & higher_mask) == '0));
endmodule

// File: tb/dma_sched_tb.sv
module dma_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] cfg_we = '0;
  logic         cfg_enable = 1'b0;
  logic [1:0]   cfg_mode = 2'd0;
  logic         cfg_repeat = 1'b0, cfg_irq_en = 1'b0, cfg_drq = 1'b0;
  logic         vblank = 1'b0, hblank = 1'b0, special_trig = 1'b0;
  logic         xfer_done = 1'b0;
  logic [N-1:0] irq_clr = '0;
  logic         cart_clr = 1'b0;
  logic [1:0]   sel_ch;
  logic         start, busy, cart_irq;
  logic [N-1:0] irq_flags;

  int checks = 0, fails = 0, start_count = 0;
  bit finished = 0;
  logic [N-1:0] exp_irq = '0;
  logic         exp_cart = 1'b0;
  bit mdl_ie [N];
  bit mdl_drq[N];

  dma_sched #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_repeat(cfg_repeat), .cfg_irq_en(cfg_irq_en),
    .cfg_drq(cfg_drq), .vblank(vblank), .hblank(hblank),
    .special_trig(special_trig), .xfer_done(xfer_done), .irq_clr(irq_clr),
    .cart_clr(cart_clr), .sel_ch(sel_ch), .start(start), .busy(busy),
    .irq_flags(irq_flags), .cart_irq(cart_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (start) start_count++;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_ch(int ch, bit en, logic [1:0] md, bit rep, bit ie, bit dq);
    @(negedge clk);
    cfg_we = '0; cfg_we[ch] = 1'b1;
    cfg_enable = en; cfg_mode = md; cfg_repeat = rep;
    cfg_irq_en = ie; cfg_drq = dq;
    mdl_ie[ch] = ie; mdl_drq[ch] = dq;
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic disable_all();
    for (int c = 0; c < N; c++) cfg_ch(c, 0, 2'd0, 0, 0, 0);
  endtask

  // which: 0 vblank, 1 hblank, 2 special
  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) vblank = 1'b1;
    else if (which == 1) hblank = 1'b1;
    else special_trig = 1'b1;
    @(negedge clk);
    vblank = 1'b0; hblank = 1'b0; special_trig = 1'b0;
  endtask

  // mid: 0 nothing, 1 hblank pulse during service, 2 disable channel 1 during service
  task automatic serve(int ch, string tag, int mid);
    for (int n = 0; n < 20 && !start; n++) @(negedge clk);
    chk(tag, "start seen", int'(start), 1);
    chk(tag, "sel_ch", int'(sel_ch), ch);
    chk("R6", "busy during service", int'(busy), 1);
    if (mid == 1) pulse(1);
    if (mid == 2) cfg_ch(1, 0, 2'd1, 0, 0, 0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    if (mdl_ie[ch]) exp_irq[ch] = 1'b1;
    if (ch == N-1 && mdl_drq[ch]) exp_cart = 1'b1;
    chk("R7", "irq_flags after done", int'(irq_flags), int'(exp_irq));
    chk("R8", "cart_irq after done", int'(cart_irq), int'(exp_cart));
  endtask

  task automatic expect_idle(string tag);
    int c0;
    c0 = start_count;
    repeat (5) @(negedge clk);
    chk(tag, "no extra start", start_count - c0, 0);
    chk("R6", "busy low when nothing pending", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "start", int'(start), 0);
    chk("R1", "irq_flags", int'(irq_flags), 0);
    chk("R1", "cart_irq", int'(cart_irq), 0);
    expect_idle("R1");
  endtask

  task automatic t_blank();
    cfg_ch(0, 1, 2'd1, 1, 1, 0);
    cfg_ch(1, 1, 2'd1, 1, 1, 0);
    cfg_ch(2, 1, 2'd2, 1, 0, 0);
    cfg_ch(3, 1, 2'd1, 1, 0, 0);
    pulse(0);
    serve(0, "R2", 0);
    serve(1, "R5", 0);
    serve(3, "R2", 0);
    expect_idle("R2");
    pulse(1);
    serve(2, "R2", 0);
    expect_idle("R2");
  endtask

  task automatic t_rescan();
    cfg_ch(0, 1, 2'd2, 1, 1, 0);
    cfg_ch(1, 0, 2'd2, 1, 0, 0);
    cfg_ch(3, 1, 2'd1, 1, 0, 0);
    pulse(0);
    serve(3, "R5", 1);
    serve(0, "R11", 0);
    serve(2, "R5", 0);
    expect_idle("R5");
  endtask

  task automatic t_special();
    disable_all();
    cfg_ch(1, 1, 2'd3, 1, 1, 0);
    cfg_ch(3, 1, 2'd3, 1, 0, 1);
    pulse(2);
    serve(3, "R3", 0);
    expect_idle("R3");
    pulse(0);
    pulse(1);
    expect_idle("R3");
  endtask

  task automatic t_clear();
    @(negedge clk);
    irq_clr = 4'b0001; cart_clr = 1'b1;
    @(negedge clk);
    irq_clr = '0; cart_clr = 1'b0;
    exp_irq[0] = 1'b0; exp_cart = 1'b0;
    chk("R7", "w1c clears only bit 0", int'(irq_flags), int'(exp_irq));
    chk("R8", "cart cleared", int'(cart_irq), 0);
    repeat (3) @(negedge clk);
    chk("R7", "flags sticky", int'(irq_flags), int'(exp_irq));
  endtask

  task automatic t_disable();
    disable_all();
    cfg_ch(2, 0, 2'd1, 1, 1, 0);
    pulse(0);
    expect_idle("R4");
    cfg_ch(0, 1, 2'd1, 1, 0, 0);
    cfg_ch(1, 1, 2'd1, 1, 1, 0);
    pulse(0);
    serve(0, "R4", 2);
    expect_idle("R4");
  endtask

  task automatic t_repeat();
    disable_all();
    cfg_ch(0, 1, 2'd1, 0, 0, 0);
    cfg_ch(1, 1, 2'd1, 1, 0, 0);
    pulse(0);
    serve(0, "R9", 0);
    serve(1, "R9", 0);
    expect_idle("R9");
    pulse(0);
    serve(1, "R9", 0);
    expect_idle("R9");
  endtask

  task automatic t_now();
    cfg_ch(2, 1, 2'd0, 0, 1, 0);
    serve(2, "R10", 0);
    expect_idle("R10");
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin mdl_ie[c] = 0; mdl_drq[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_blank();
    t_rescan();
    t_special();
    t_clear();
    t_disable();
    t_repeat();
    t_now();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule